// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of why the device most recently left reset or woke from its low-power stop state. It shows that record as an 8-bit read-only status byte. Each cause event arrives as a one-cycle pulse: power-on reset, external reset pin, watchdog time-out, debugger-requested reset, and wake-up from stop by a GPIO transition or by the debug pin driven low. A watchdog time-out counts as a wake-up from stop when the in-stop level is high in the same cycle. Otherwise it counts as a watchdog reset.

Software reads the byte through a single read strobe. The read returns the stored record, and the record then clears. A new event always replaces the whole cause field. It is never merged into the old value. The power-on input doubles as the block's asynchronous reset.

Top module: `wake_cause_status`

## Requirements
- R1: While `pwrOnRst` is high, and after it falls, the stored byte is 0x80. The byte layout is bit 7 = power-on, bit 6 = stop wake-up, bit 5 = watchdog, bit 4 = external pin.
- R2: Bits 3:0 of `rdData` always read 0.
- R3: An `extRst` pulse stores 0x10.
- R4: A `wdtTimeout` pulse with `inStop` low stores 0x20.
- R5: A `dbgRst` pulse stores 0x80.
- R6: A `wakeGpio` or `wakeDbgPin` pulse stores 0x40.
- R7: A `wdtTimeout` pulse with `inStop` high stores 0x60.
- R8: During a cycle with `rdStb` high, `rdData` shows the stored byte. From the next cycle on, the byte reads 0x00, provided no event came in that cycle.
- R9: An event overwrites all four cause bits with its own pattern, whatever was stored before.
- R10: When an event and `rdStb` fall in the same cycle, the read returns the old byte and the event's pattern is what remains stored.
- R11: Among events in the same cycle, the priority is debugger, then external pin, then watchdog, then stop wake-up by GPIO or debug pin.
- R12: With no event and no read, the stored byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrOnRst | input | 1 | Power-on reset, active high, asynchronous |
| extRst | input | 1 | External reset pin event pulse |
| wdtTimeout | input | 1 | Watchdog time-out pulse |
| dbgRst | input | 1 | Debugger-requested reset pulse |
| wakeGpio | input | 1 | Stop wake-up by GPIO transition, pulse |
| wakeDbgPin | input | 1 | Stop wake-up by debug pin low, pulse |
| inStop | input | 1 | Level, high while the device is in stop mode |
| rdStb | input | 1 | Read strobe; clears the record after the cycle |
| rdData | output | 8 | Status byte: cause bits 7:4, zeros in 3:0 |

## Verification
The assertions assume that event inputs are synchronous to `clk` and that `pwrOnRst` is the only input allowed to change asynchronously. They accept events and reads in any combination within one cycle. The stimulus drives every input one time unit after a rising edge and holds it for one whole cycle. It raises `pwrOnRst` only between sequences. It deliberately combines events with each other and with reads, so that the priority and overlap assumptions are exercised inside their legal range.

// File: rtl/wake_cause_pkg.sv
package wake_cause_pkg;
  localparam int DATA_W  = 8;
  localparam int CAUSE_W = 4;
  localparam int RSV_W   = DATA_W - CAUSE_W;

  typedef struct packed {
    logic por;
    logic stop;
    logic wdt;
    logic ext;
  } cause_t;

  typedef struct packed {
    logic   load;
    logic   clear;
    cause_t pattern;
  } strobe_t;

  localparam cause_t PAT_POR      = '{por: 1'b1, stop: 1'b0, wdt: 1'b0, ext: 1'b0};
  localparam cause_t PAT_EXT      = '{por: 1'b0, stop: 1'b0, wdt: 1'b0, ext: 1'b1};
  localparam cause_t PAT_WDT      = '{por: 1'b0, stop: 1'b0, wdt: 1'b1, ext: 1'b0};
  localparam cause_t PAT_WAKE     = '{por: 1'b0, stop: 1'b1, wdt: 1'b0, ext: 1'b0};
  localparam cause_t PAT_WDT_WAKE = '{por: 1'b0, stop: 1'b1, wdt: 1'b1, ext: 1'b0};
endpackage

// File: rtl/wake_cause_ctrl.sv
module wake_cause_ctrl
  import wake_cause_pkg::*;
(
  input  logic    clk,
  input  logic    pwrOnRst,
  input  logic    extRst,
  input  logic    wdtTimeout,
  input  logic    dbgRst,
  input  logic    wakeGpio,
  input  logic    wakeDbgPin,
  input  logic    inStop,
  input  logic    rdStb,
  output strobe_t strb
);
  logic anyEvent;

  assign anyEvent = dbgRst | extRst | wdtTimeout | wakeGpio | wakeDbgPin;

  // priority chain: debugger, external pin, watchdog, stop wake-up
  always_comb begin
    strb.load    = anyEvent;
    strb.clear   = rdStb;
    strb.pattern = '0;
    if (dbgRst)                   strb.pattern = PAT_POR;
    else if (extRst)              strb.pattern = PAT_EXT;
    else if (wdtTimeout)          strb.pattern = inStop ? PAT_WDT_WAKE : PAT_WDT;
    else if (wakeGpio | wakeDbgPin) strb.pattern = PAT_WAKE;
  end

  assert_dbg_first_R11: assert property (@(posedge clk) disable iff (pwrOnRst)
    dbgRst |-> (strb.load && strb.pattern == PAT_POR));

  assert_ext_over_wdt_R11: assert property (@(posedge clk) disable iff (pwrOnRst)
    (extRst && !dbgRst) |-> (strb.pattern == PAT_EXT));

  assert_wdt_in_stop_R7: assert property (@(posedge clk) disable iff (pwrOnRst)
    (wdtTimeout && inStop && !dbgRst && !extRst) |-> (strb.pattern.stop && strb.pattern.wdt));

  assert_wake_R6: assert property (@(posedge clk) disable iff (pwrOnRst)
    ((wakeGpio || wakeDbgPin) && !dbgRst && !extRst && !wdtTimeout)
      |-> (strb.pattern == PAT_WAKE));
endmodule

// File: rtl/wake_cause_dp.sv
module wake_cause_dp
  import wake_cause_pkg::*;
(
  input  logic              clk,
  input  logic              pwrOnRst,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] rdData
);
  cause_t cause;

  // an event wins over the clear-on-read in the same cycle
  always_ff @(posedge clk or posedge pwrOnRst) begin
    if (pwrOnRst)        cause <= PAT_POR;
    else if (strb.load)  cause <= strb.pattern;
    else if (strb.clear) cause <= '0;
  end

  assign rdData = {cause, {RSV_W{1'b0}}};

  assert_load_R9: assert property (@(posedge clk) disable iff (pwrOnRst)
    strb.load |=> (cause == $past(strb.pattern)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (pwrOnRst)
    (strb.clear && !strb.load) |=> (cause == '0));

  assert_hold_R12: assert property (@(posedge clk) disable iff (pwrOnRst)
    (!strb.load && !strb.clear) |=> $stable(cause));

  assert_excl_R11: assert property (@(posedge clk) disable iff (pwrOnRst)
    $onehot0({cause.por, cause.stop, cause.ext}) && !(cause.wdt && (cause.por || cause.ext)));
endmodule

// File: rtl/wake_cause_status.sv
module wake_cause_status
  import wake_cause_pkg::*;
(
  input  logic              clk,
  input  logic              pwrOnRst,
  input  logic              extRst,
  input  logic              wdtTimeout,
  input  logic              dbgRst,
  input  logic              wakeGpio,
  input  logic              wakeDbgPin,
  input  logic              inStop,
  input  logic              rdStb,
  output logic [DATA_W-1:0] rdData
);
  strobe_t strb;

  wake_cause_ctrl u_ctrl (
    .clk        (clk),
    .pwrOnRst   (pwrOnRst),
    .extRst     (extRst),
    .wdtTimeout (wdtTimeout),
    .dbgRst     (dbgRst),
    .wakeGpio   (wakeGpio),
    .wakeDbgPin (wakeDbgPin),
    .inStop     (inStop),
    .rdStb      (rdStb),
    .strb       (strb)
  );

  wake_cause_dp u_dp (
    .clk      (clk),
    .pwrOnRst (pwrOnRst),
    .strb     (strb),
    .rdData   (rdData)
  );

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (pwrOnRst)
    rdData[RSV_W-1:0] == '0);
endmodule

// File: tb/wake_cause_status_test.sv
module wake_cause_status_test;
  logic clk = 1'b0;
  logic pwrOnRst = 1'b1;
  logic extRst = 0, wdtTimeout = 0, dbgRst = 0, wakeGpio = 0, wakeDbgPin = 0;
  logic inStop = 0, rdStb = 0;
  logic [7:0] rdData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  wake_cause_status uut (.*);

  always #2.5 clk = ~clk;

  // ev = {dbg, ext, wdt, gpio, dbgPin, inStop}
  task automatic cyc(input logic [5:0] ev, input logic rd, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    {dbgRst, extRst, wdtTimeout, wakeGpio, wakeDbgPin, inStop} = ev;
    rdStb = rd;
    if (rd) begin
      it.exp = exp;
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  task automatic idle();
    cyc(6'b0, 1'b0, 8'h00, "");
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    cyc(6'b0, 1'b1, exp, tag);
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: reads are sampled mid-cycle, before the clearing edge
  always @(negedge clk) begin
    if (!pwrOnRst && rdStb) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=%h expected=none", rdData);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rdData, it.exp, it.tag);
      end
    end
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    check(rdData, 8'h80, "R1 during reset");
    @(negedge clk);
    pwrOnRst = 1'b0;
    rd(8'h80, "R1 after reset");
    rd(8'h00, "R8 cleared after read");
    cyc(6'b010000, 0, 0, ""); rd(8'h10, "R3 ext pin");
    rd(8'h00, "R8 clear after ext");
    cyc(6'b001000, 0, 0, ""); rd(8'h20, "R4 wdt not in stop");
    cyc(6'b100000, 0, 0, ""); rd(8'h80, "R5 debugger reset");
    cyc(6'b000100, 0, 0, ""); rd(8'h40, "R6 gpio wake");
    cyc(6'b000010, 0, 0, ""); rd(8'h40, "R6 debug pin wake");
    cyc(6'b001001, 0, 0, ""); rd(8'h60, "R7 wdt wake in stop");
    cyc(6'b001001, 0, 0, ""); cyc(6'b010000, 0, 0, ""); rd(8'h10, "R9 overwrite not OR");
    cyc(6'b000100, 0, 0, ""); cyc(6'b100000, 0, 0, ""); rd(8'h80, "R9 overwrite stop by dbg");
    cyc(6'b010000, 0, 0, ""); cyc(6'b001000, 1, 8'h10, "R10 old value on read");
    rd(8'h20, "R10 event kept after read");
    cyc(6'b111110, 0, 0, ""); rd(8'h80, "R11 debugger first");
    cyc(6'b011110, 0, 0, ""); rd(8'h10, "R11 ext over wdt");
    cyc(6'b001110, 0, 0, ""); rd(8'h20, "R11 wdt over wake");
    cyc(6'b001111, 0, 0, ""); rd(8'h60, "R11 wdt wake over gpio");
    cyc(6'b010000, 0, 0, "");
    for (int i = 0; i < 5; i++) idle();
    rd(8'h10, "R12 hold without read");
    rd(8'h00, "R12 R8 cleared");
    for (int i = 0; i < 3; i++) idle();
    rd(8'h00, "R12 zero holds");
    idle();
    @(negedge clk);
    pwrOnRst = 1'b1;
    #1;
    check(rdData, 8'h80, "R1 async reset");
    check({4'h0, rdData[3:0]}, 8'h00, "R2 reserved zero");
    @(negedge clk);
    pwrOnRst = 1'b0;
    rd(8'h80, "R1 after second reset");
    idle();
    idle();
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", sb.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule